// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block gates the clocks of a small processor subsystem and moves it between a run mode, a CPU-idle mode and a frequency-change window. Software writes a staged core clock configuration word and then a change request. The controller opens the change by applying the memory bus divide-by-two if the new setting needs it. It then holds the CPU, memory controller, display controller and DMA clocks off while a lock counter stands in for PLL settling. Once the count expires, the new configuration becomes active.

An idle request stops only the CPU clock. The always-on domain keeps running in idle, during frequency changes and in run mode. That domain holds the real-time clock, the OS timers, the watchdog and the GPIO interrupt logic. A wake-qualification bit decides whether a unit-level enabled interrupt is enough to end idle, or whether the interrupt must also be unmasked. Software lowers the clock to a reduced setting (0x13F) before entering idle. Raising the clock back up after wake is an ordinary later change.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: After reset, every clock enable is 1, `cfg_active` is 0x010, `mem_div2` is 0, `chg_done` is 0, `in_idle` is 0, the wake-qualification bit is 0 and the lock count is 4.
- R2: Register writes use `wr_addr`. Address 0 loads the staged configuration. Address 1 with bit 0 set requests a change. Address 2 with bit 0 set requests idle. Address 3 bit 0 is the wake-qualification bit. Address 4 loads the lock count (low 8 bits).
- R3: A change request accepted in run mode gives one cycle with all clocks on. Then `cpu_clk_en`, `mem_clk_en`, `lcd_clk_en` and `dma_clk_en` are 0 for max(lock count, 1) cycles while `aon_clk_en` stays 1. On the edge that re-enables them, `cfg_active` takes the target and `chg_done` becomes 1.
- R4: If the target has bit 9 (memory divide-by-two needed) set, `mem_div2` is 1 from the cycle after the request write, before the gated window begins.
- R5: If the target has bit 9 clear, an active `mem_div2` stays 1 throughout the gated window and falls on the edge where the clocks return.
- R6: While clocks are gated, `refresh_speed` is the smaller of the speed fields (bits 4:0) of the current and target configurations. Otherwise it is the current speed field.
- R7: An idle request in run mode sets `in_idle` and clears `cpu_clk_en`, while the memory, display, DMA and always-on enables stay 1.
- R8: With the qualification bit 0, any source with `irq_req` and `irq_en` both 1 ends idle, whatever its mask bit. A request without enable does not.
- R9: With the qualification bit 1, a source ends idle only if `irq_req` and `irq_en` are 1 and `irq_mask` is 0.
- R10: `wake_req` rises in the same cycle a qualifying interrupt is present in idle. On the next edge `in_idle` clears and `cpu_clk_en` returns.
- R11: A change request written while idle is ignored: no gating follows and `cfg_active` is unchanged, even when a wake ends idle on that same edge.
- R12: A change request written during a change is held. When the first change completes, the second starts at once with the staged value present at that moment.
- R13: A change to 0x13F completes like any other, and idle may then be entered.
- R14: An idle request written during a change is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CFG_W | Register write data |
| irq_req | input | NSRC | Raw interrupt request per source |
| irq_en | input | NSRC | Unit-level interrupt enable per source |
| irq_mask | input | NSRC | Interrupt mask per source, 1 = masked |
| cpu_clk_en | output | 1 | CPU clock enable |
| mem_clk_en | output | 1 | Memory controller clock enable |
| lcd_clk_en | output | 1 | Display controller clock enable |
| dma_clk_en | output | 1 | DMA clock enable |
| aon_clk_en | output | 1 | Enable for RTC, OS timers, watchdog and GPIO logic |
| mem_div2 | output | 1 | Memory bus divide-by-two select |
| refresh_speed | output | SPD_W | Speed code for which the refresh interval is chosen |
| cfg_active | output | CFG_W | Configuration currently in force |
| chg_done | output | 1 | Last frequency change has completed |
| in_idle | output | 1 | Idle mode is active |
| wake_req | output | 1 | Qualified interrupt is ending idle |

## Verification
Two pairs of events can land on one clock edge. In the first, a wake interrupt and a change request reach the controller on the same edge while it is idle. The bench drives both in one cycle and then expects idle to end, the clocks to stay on and the active configuration to stay as it was. In the second, a change request arrives while a change is in progress. The bench writes it during the lock window and expects a single cycle of running clocks between the two gated windows, with the active configuration stepping from the first target to the second.

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl #(
  parameter int NSRC     = 8,
  parameter int CFG_W    = 10,
  parameter int SPD_W    = 5,
  parameter int LOCK_W   = 8,
  parameter logic [CFG_W-1:0]  CFG_RST  = 10'h010,
  parameter logic [LOCK_W-1:0] LOCK_RST = 8'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CFG_W-1:0] wr_data,
  input  logic [NSRC-1:0]  irq_req,
  input  logic [NSRC-1:0]  irq_en,
  input  logic [NSRC-1:0]  irq_mask,
  output logic             cpu_clk_en,
  output logic             mem_clk_en,
  output logic             lcd_clk_en,
  output logic             dma_clk_en,
  output logic             aon_clk_en,
  output logic             mem_div2,
  output logic [SPD_W-1:0] refresh_speed,
  output logic [CFG_W-1:0] cfg_active,
  output logic             chg_done,
  output logic             in_idle,
  output logic             wake_req
);
  localparam int DIV_BIT = CFG_W - 1;

  typedef enum logic [1:0] {S_RUN, S_PRE, S_LOCK, S_IDLE} state_t;

  state_t              st;
  logic [CFG_W-1:0]    cfg_stage, cfg_tgt;
  logic [LOCK_W-1:0]   lock_len, cnt;
  logic                qual, pend;

  wire chg_wr  = wr_en && (wr_addr == 3'd1) && wr_data[0];
  wire idle_wr = wr_en && (wr_addr == 3'd2) && wr_data[0];
  wire last    = (cnt <= LOCK_W'(1));
  wire gated   = (st == S_LOCK);

  wire [NSRC-1:0] qualified = irq_req & irq_en & (qual ? ~irq_mask : {NSRC{1'b1}});
  wire            wake_hit  = |qualified;

  wire [SPD_W-1:0] cur_spd = cfg_active[SPD_W-1:0];
  wire [SPD_W-1:0] tgt_spd = cfg_tgt[SPD_W-1:0];

  assign cpu_clk_en    = (st == S_RUN) || (st == S_PRE);
  assign mem_clk_en    = !gated;
  assign lcd_clk_en    = !gated;
  assign dma_clk_en    = !gated;
  assign aon_clk_en    = 1'b1;
  assign in_idle       = (st == S_IDLE);
  assign wake_req      = in_idle && wake_hit;
  assign refresh_speed = (gated && tgt_spd < cur_spd) ? tgt_spd : cur_spd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RUN;
      cfg_stage  <= CFG_RST;
      cfg_tgt    <= CFG_RST;
      cfg_active <= CFG_RST;
      lock_len   <= LOCK_RST;
      cnt        <= '0;
      qual       <= 1'b0;
      pend       <= 1'b0;
      mem_div2   <= 1'b0;
      chg_done   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          3'd0:    cfg_stage <= wr_data;
          3'd3:    qual      <= wr_data[0];
          3'd4:    lock_len  <= wr_data[LOCK_W-1:0];
          default: ;
        endcase
      end
      case (st)
        S_RUN: begin
          if (chg_wr) begin
            cfg_tgt  <= cfg_stage;
            cnt      <= lock_len;
            mem_div2 <= mem_div2 | cfg_stage[DIV_BIT];
            chg_done <= 1'b0;
            st       <= S_PRE;
          end else if (idle_wr) begin
            st <= S_IDLE;
          end
        end
        S_PRE: begin
          st <= S_LOCK;
          if (chg_wr) pend <= 1'b1;
        end
        S_LOCK: begin
          if (last) begin
            cfg_active <= cfg_tgt;
            if (pend || chg_wr) begin
              cfg_tgt  <= cfg_stage;
              cnt      <= lock_len;
              mem_div2 <= cfg_tgt[DIV_BIT] | cfg_stage[DIV_BIT];
              chg_done <= 1'b0;
              pend     <= 1'b0;
              st       <= S_PRE;
            end else begin
              mem_div2 <= cfg_tgt[DIV_BIT];
              chg_done <= 1'b1;
              st       <= S_RUN;
            end
          end else begin
            cnt <= cnt - LOCK_W'(1);
            if (chg_wr) pend <= 1'b1;
          end
        end
        S_IDLE: begin
          if (wake_hit) st <= S_RUN;
        end
        default: st <= S_RUN;
      endcase
    end
  end
endmodule

module clk_pwr_ctrl_chk #(
  parameter int CFG_W = 10,
  parameter int SPD_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_clk_en,
  input logic             mem_clk_en,
  input logic             lcd_clk_en,
  input logic             dma_clk_en,
  input logic             aon_clk_en,
  input logic             mem_div2,
  input logic [SPD_W-1:0] refresh_speed,
  input logic [CFG_W-1:0] cfg_active,
  input logic             chg_done,
  input logic             in_idle,
  input logic             wake_req
);
  p_idle_cpu_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> (!cpu_clk_en && mem_clk_en && aon_clk_en));

  p_wake_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> (!in_idle && cpu_clk_en));

  p_gate_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && !in_idle) |-> (!mem_clk_en && !lcd_clk_en && !dma_clk_en && aon_clk_en));

  p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_active) |-> $rose(mem_clk_en));

  p_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_done) |-> $rose(mem_clk_en));

  p_div_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_div2) |-> (mem_clk_en && cpu_clk_en));

  p_div_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_div2) |-> $rose(mem_clk_en));

  p_refresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_clk_en |-> (refresh_speed <= cfg_active[SPD_W-1:0]));
endmodule

bind clk_pwr_ctrl clk_pwr_ctrl_chk #(.CFG_W(CFG_W), .SPD_W(SPD_W)) u_chk (.*);

// File: tb/tb_clk_pwr_ctrl.sv
module tb_clk_pwr_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic [7:0] irq_req = '0, irq_en = '0, irq_mask = '0;
  logic       cpu_clk_en, mem_clk_en, lcd_clk_en, dma_clk_en, aon_clk_en;
  logic       mem_div2, chg_done, in_idle, wake_req;
  logic [4:0] refresh_speed;
  logic [9:0] cfg_active;
  int total = 0, fails = 0;

  clk_pwr_ctrl dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Called in the running cycle after a request; returns at the first negedge with clocks back.
  task automatic gate_run(output int n, output logic aon_ok, output logic sub_ok,
                          output logic [4:0] rs);
    n = 0; aon_ok = 1'b1; sub_ok = 1'b1; rs = '0;
    @(negedge clk);
    while (!cpu_clk_en) begin
      n++;
      if (!aon_clk_en) aon_ok = 1'b0;
      if (mem_clk_en || lcd_clk_en || dma_clk_en) sub_ok = 1'b0;
      rs = refresh_speed;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 cpu", cpu_clk_en, 1); chk("R1 mem", mem_clk_en, 1);
    chk("R1 aon", aon_clk_en, 1); chk("R1 cfg", cfg_active, 10'h010);
    chk("R1 div", mem_div2, 0);   chk("R1 done", chg_done, 0);
    chk("R1 idle", in_idle, 0);
  endtask

  task automatic t_change_up;
    int n; logic a, s; logic [4:0] rs;
    wr(3'd4, 10'd3); wr(3'd0, 10'h21A); wr(3'd1, 10'd1);
    chk("R4 div before gate", mem_div2, 1);
    chk("R2 R3 clocks on in first cycle", cpu_clk_en, 1);
    gate_run(n, a, s, rs);
    chk("R3 gated cycles", n, 3); chk("R3 aon kept", a, 1);
    chk("R3 subset gated", s, 1); chk("R6 refresh slower", rs, 5'h10);
    chk("R3 cfg committed", cfg_active, 10'h21A); chk("R3 done", chg_done, 1);
    chk("R6 refresh idle of change", refresh_speed, 5'h1A);
  endtask

  task automatic t_change_down;
    int n; logic a, s; logic [4:0] rs; logic div_in_gate;
    wr(3'd0, 10'h014); wr(3'd1, 10'd1);
    chk("R3 done cleared on accept", chg_done, 0);
    @(negedge clk);
    div_in_gate = mem_div2;
    n = 1; rs = refresh_speed;
    while (!cpu_clk_en) begin @(negedge clk); if (!cpu_clk_en) n++; end
    chk("R5 div held in gate", div_in_gate, 1);
    chk("R5 div cleared after", mem_div2, 0);
    chk("R6 refresh slower down", rs, 5'h14);
    chk("R3 gated cycles down", n, 3);
    chk("R3 cfg down", cfg_active, 10'h014);
    wr(3'd4, 10'd0); wr(3'd0, 10'h016); wr(3'd1, 10'd1);
    gate_run(n, a, s, rs);
    chk("R3 zero lock one cycle", n, 1);
  endtask

  task automatic t_pending;
    int n; logic a, s; logic [4:0] rs;
    wr(3'd4, 10'd6); wr(3'd0, 10'h013); wr(3'd1, 10'd1);
    wr(3'd0, 10'h011); wr(3'd1, 10'd1);
    wr(3'd2, 10'd1);
    while (!cpu_clk_en) @(negedge clk);
    chk("R12 first target", cfg_active, 10'h013);
    gate_run(n, a, s, rs);
    chk("R12 second gated", n, 6);
    chk("R12 second target", cfg_active, 10'h011);
    chk("R12 done", chg_done, 1);
    chk("R14 idle write ignored", in_idle, 0);
  endtask

  task automatic t_idle_q0;
    wr(3'd2, 10'd1);
    chk("R7 idle", in_idle, 1); chk("R7 cpu off", cpu_clk_en, 0);
    chk("R7 mem on", mem_clk_en, 1); chk("R7 dma on", dma_clk_en, 1);
    chk("R7 aon on", aon_clk_en, 1);
    irq_req = 8'h01; irq_en = 8'h00;
    repeat (3) @(negedge clk);
    chk("R8 unenabled no wake", in_idle, 1);
    irq_req = 8'h04; irq_en = 8'h04; irq_mask = 8'h04;
    #1 chk("R10 R8 wake same cycle", wake_req, 1);
    @(negedge clk);
    chk("R10 idle cleared", in_idle, 0); chk("R10 cpu back", cpu_clk_en, 1);
    irq_req = 0; irq_en = 0; irq_mask = 0;
  endtask

  task automatic t_idle_q1;
    wr(3'd3, 10'd1); wr(3'd2, 10'd1);
    irq_req = 8'h04; irq_en = 8'h04; irq_mask = 8'h04;
    repeat (3) @(negedge clk);
    chk("R9 masked stays idle", in_idle, 1);
    chk("R9 masked no wake_req", wake_req, 0);
    irq_mask = 8'h00;
    #1 chk("R9 unmasked wake", wake_req, 1);
    @(negedge clk);
    chk("R9 exit", in_idle, 0);
    irq_req = 0; irq_en = 0;
  endtask

  task automatic t_idle_change;
    int on_cnt = 0;
    wr(3'd0, 10'h01C); wr(3'd2, 10'd1); wr(3'd1, 10'd1);
    repeat (3) begin @(negedge clk); if (mem_clk_en && in_idle) on_cnt++; end
    chk("R11 request in idle ignored", on_cnt, 3);
    chk("R11 cfg kept", cfg_active, 10'h011);
    @(negedge clk);
    irq_req = 8'h80; irq_en = 8'h80; irq_mask = 8'h00;
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 10'd1;
    @(negedge clk);
    wr_en = 1'b0; irq_req = 0; irq_en = 0;
    chk("R11 R10 woke", in_idle, 0);
    on_cnt = 0;
    repeat (8) begin if (cpu_clk_en && mem_clk_en) on_cnt++; @(negedge clk); end
    chk("R11 no gating after same-cycle request", on_cnt, 8);
    chk("R11 cfg unchanged", cfg_active, 10'h011);
  endtask

  task automatic t_slow_idle;
    int n; logic a, s; logic [4:0] rs;
    wr(3'd4, 10'd2); wr(3'd0, 10'h13F); wr(3'd1, 10'd1);
    gate_run(n, a, s, rs);
    chk("R13 cfg 0x13F", cfg_active, 10'h13F);
    chk("R13 div clear", mem_div2, 0);
    wr(3'd2, 10'd1);
    chk("R13 idle after slow change", in_idle, 1);
    irq_req = 8'h02; irq_en = 8'h02;
    @(negedge clk);
    chk("R13 wake from slow idle", in_idle, 0);
    irq_req = 0; irq_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_change_up();
    t_change_down();
    t_pending();
    t_idle_q0();
    t_idle_q1();
    t_idle_change();
    t_slow_idle();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule